// File: doc/BRIEF.md
# CPU Cluster Clock Rate Switch Sequencer

This controller moves one CPU cluster clock to a new rate. A request carries a 4-bit rate code and is taken on a valid/ready handshake. Codes with bit 3 set are rates above a 1 GHz threshold. These are produced by the system PLL through the final source mux, and the low three bits of the code are the PLL setting. Codes with bit 3 clear are at or below the threshold. These are produced by dividing the fixed PLL through one of two alternating dynamic divider paths. Code 7 is the threshold rate itself.

The controller reads and rewrites a 32-bit clock-control word held outside the block. Before each rewrite it checks the word's busy flag, retrying a limited number of times with a wait between attempts. It drives a request/acknowledge port to retune the PLL. It ends every request with a one-cycle done pulse and a 2-bit result code. It keeps the current rate code, which changes only after a fully successful sequence.

States: `S_IDLE` (ready, waits for a request), `S_LOOKUP` (table check of the divided-path setting), `S_POLL` (busy polling), `S_WRITE` (one control-word write), `S_PLL` (PLL retune handshake) and `S_DONE` (result pulse). The transitions are as follows:
- IDLE goes to LOOKUP for a low target, or for a high target when the current rate is also high (the step through code 7).
- IDLE goes to PLL for a high target when the current rate is low.
- LOOKUP goes to POLL on a table hit, or to DONE on a miss.
- POLL goes to WRITE when the flag is clear, or to DONE on timeout.
- WRITE goes to PLL after the intermediate step, or to DONE otherwise.
- PLL goes to POLL on acknowledge, or to DONE on timeout.
- DONE returns to IDLE.

Top module: `clk_rate_sequencer`

## Requirements
- R1: After reset, req_ready is 1, done, ctl_we and pll_req are 0, and cur_rate equals RESET_CODE (default 7).
- R2: A request with code bit 3 clear, for a table entry that exists, writes the control word once. The write has source bit 0 cleared and dynamic-select bit 1 inverted. It loads the path that the new select value names with the entry's fields and leaves the other path's fields unchanged. Path 0 holds divider [7:2], pre-mux [9:8] and post-mux [10]. Path 1 holds divider [16:11], pre-mux [18:17] and post-mux [19]. For entry c the divider is 2c+1, the pre-mux is c mod 4 and the post-mux is bit 2 of c. No PLL request is made.
- R3: Table entries 5 and 6 do not exist. A request for them ends with result 01, with no control write and no PLL request.
- R4: From a low current rate, a high request raises pll_req with pll_rate equal to the code's low three bits. pll_req holds until pll_ack. Then one write sets source bit 0 to 1 and leaves every other field unchanged.
- R5: From a high current rate, a high request first performs the full R2 switch to code 7, and only then starts the R4 sequence.
- R6: Every write follows a cycle in which busy bit 31 was read as 0. The flag is sampled up to TRIES (5) times, POLL_WAIT (1024) cycles apart. If it is still set on the last sample, the result is 10 and no write is made.
- R7: If pll_ack has not arrived within PLL_WAIT cycles, pll_req drops, the result is 11, and no source write follows.
- R8: cur_rate takes the requested code only on a done with result 00. It never changes at any other time.
- R9: req_ready is low from acceptance until after done, and requests presented meanwhile are ignored. done lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Rate request present |
| req_rate | input | 4 | Requested rate code (bit 3 = above threshold) |
| req_ready | output | 1 | Request accepted when high with req_valid |
| ctl_rdata | input | 32 | Current clock-control word (bit 31 busy) |
| ctl_we | output | 1 | Control word write strobe |
| ctl_wdata | output | 32 | Control word to write |
| pll_req | output | 1 | PLL retune request |
| pll_rate | output | 3 | PLL setting requested |
| pll_ack | input | 1 | PLL retune acknowledge |
| done | output | 1 | Sequence finished (one cycle) |
| err | output | 2 | Result: 00 ok, 01 unsupported, 10 busy timeout, 11 no PLL ack |
| cur_rate | output | 4 | Current rate code |

## Verification
Successive low-rate requests show whether the select bit truly alternates and whether the idle path is preserved. Low-to-high and high-to-high requests differ only in whether an intermediate divided-path write to code 7 comes before the PLL handshake, so the expected write queue separates them. A busy flag released after the second poll distinguishes retry from a single sample, and a flag that never clears gives the timeout. A withheld acknowledge, issued from a high current rate, shows the intermediate write surviving while cur_rate stays at its old value.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;

    localparam int CODE_W = 4;
    localparam int LOW_W  = CODE_W - 1;
    localparam int DIV_W  = 6;
    localparam int PRE_W  = 2;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ERR_OK    = 2'b00,
        ERR_UNSUP = 2'b01,
        ERR_BUSY  = 2'b10,
        ERR_NOACK = 2'b11
    } err_e;

    typedef struct packed {
        logic             busy;
        logic [10:0]      rsvd;
        logic             post1;
        logic [PRE_W-1:0] pre1;
        logic [DIV_W-1:0] div1;
        logic             post0;
        logic [PRE_W-1:0] pre0;
        logic [DIV_W-1:0] div0;
        logic             sel;
        logic             src;
    } ctl_word_t;

    typedef struct packed {
        logic             ok;
        logic [DIV_W-1:0] div;
        logic [PRE_W-1:0] pre;
        logic             post;
    } rate_ent_t;

    localparam logic SRC_FIXED = 1'b0;
    localparam logic SRC_PLL   = 1'b1;

endpackage

// File: rtl/clk_rate_rom.sv
module clk_rate_rom
    import clk_seq_pkg::*;
#(
    parameter int          ENTRIES    = 8,
    parameter logic [7:0]  ABSENT_MAP = 8'b0110_0000,
    localparam int         IDX_W      = $clog2(ENTRIES)
) (
    input  logic [IDX_W-1:0] idx,
    output rate_ent_t        ent
);

    rate_ent_t table_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        localparam logic [DIV_W-1:0] DIVV = DIV_W'(2 * g + 1);
        localparam logic [PRE_W-1:0] PREV = PRE_W'(g % 4);
        localparam logic             POSTV = 1'((g >> 2) & 1);
        assign table_q[g] = '{ok: ~ABSENT_MAP[g], div: DIVV, pre: PREV, post: POSTV};
    end

    assign ent = table_q[idx];

endmodule

// File: rtl/clk_busy_poll.sv
module clk_busy_poll #(
    parameter int TRIES     = 5,
    parameter int POLL_WAIT = 1024,
    localparam int TRY_W    = $clog2(TRIES + 1),
    localparam int WAIT_W   = $clog2(POLL_WAIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic busy,
    output logic clear,
    output logic expired
);

    typedef enum logic [1:0] {P_IDLE, P_CHECK, P_WAIT} pst_e;

    pst_e              pst, pst_d;
    logic [TRY_W-1:0]  tries_q;
    logic [WAIT_W-1:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pst <= P_IDLE;
        end else begin
            pst <= pst_d;
        end
    end

    always_comb begin
        pst_d = pst;
        unique case (pst)
            P_IDLE:  if (en) pst_d = P_CHECK;
            P_CHECK: begin
                if (!busy || tries_q == TRY_W'(TRIES)) pst_d = P_IDLE;
                else                                    pst_d = P_WAIT;
            end
            P_WAIT:  if (wait_q == WAIT_W'(POLL_WAIT - 1)) pst_d = P_CHECK;
            default: pst_d = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries_q <= '0;
            wait_q  <= '0;
        end else begin
            unique case (pst)
                P_IDLE: begin
                    tries_q <= TRY_W'(1);
                    wait_q  <= '0;
                end
                P_CHECK: wait_q <= '0;
                P_WAIT: begin
                    wait_q <= wait_q + 1'b1;
                    if (wait_q == WAIT_W'(POLL_WAIT - 1)) tries_q <= tries_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        clear   = (pst == P_CHECK) && !busy;
        expired = (pst == P_CHECK) && busy && (tries_q == TRY_W'(TRIES));
    end

endmodule

// File: rtl/clk_rate_sequencer.sv
module clk_rate_sequencer
    import clk_seq_pkg::*;
#(
    parameter int          TRIES       = 5,
    parameter int          POLL_WAIT   = 1024,
    parameter int          PLL_WAIT    = 64,
    parameter logic [3:0]  RESET_CODE  = 4'd7,
    parameter logic [2:0]  THRESH_CODE = 3'd7,
    localparam int         PW_W        = $clog2(PLL_WAIT)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [3:0]  req_rate,
    output logic        req_ready,
    input  logic [31:0] ctl_rdata,
    output logic        ctl_we,
    output logic [31:0] ctl_wdata,
    output logic        pll_req,
    output logic [2:0]  pll_rate,
    input  logic        pll_ack,
    output logic        done,
    output logic [1:0]  err,
    output logic [3:0]  cur_rate
);

    typedef enum logic [2:0] {S_IDLE, S_LOOKUP, S_POLL, S_WRITE, S_PLL, S_DONE} st_e;

    st_e              st, st_d;
    logic [CODE_W-1:0] tgt_q, cur_q;
    logic [LOW_W-1:0]  step_q;
    logic              via_q;
    logic              kind_pll_q;
    err_e              err_q;
    logic [PW_W-1:0]   pll_cnt;

    rate_ent_t ent;
    logic      poll_clear, poll_expired;
    logic      pll_late;
    ctl_word_t rd_w, wr_w;

    clk_rate_rom #(.ENTRIES(1 << LOW_W)) u_rom (
        .idx (step_q),
        .ent (ent)
    );

    clk_busy_poll #(.TRIES(TRIES), .POLL_WAIT(POLL_WAIT)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (st == S_POLL),
        .busy    (ctl_rdata[WORD_W-1]),
        .clear   (poll_clear),
        .expired (poll_expired)
    );

    assign rd_w     = ctl_word_t'(ctl_rdata);
    assign pll_late = (pll_cnt == PW_W'(PLL_WAIT - 1)) && !pll_ack;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_d;
    end

    // next state
    always_comb begin
        st_d = st;
        unique case (st)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_rate[CODE_W-1] && !cur_q[CODE_W-1]) st_d = S_PLL;
                    else                                       st_d = S_LOOKUP;
                end
            end
            S_LOOKUP: st_d = ent.ok ? S_POLL : S_DONE;
            S_POLL: begin
                if (poll_clear)        st_d = S_WRITE;
                else if (poll_expired) st_d = S_DONE;
            end
            S_WRITE: st_d = (!kind_pll_q && via_q) ? S_PLL : S_DONE;
            S_PLL: begin
                if (pll_ack)       st_d = S_POLL;
                else if (pll_late) st_d = S_DONE;
            end
            S_DONE:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // sequence data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q      <= '0;
            cur_q      <= RESET_CODE;
            step_q     <= '0;
            via_q      <= 1'b0;
            kind_pll_q <= 1'b0;
            err_q      <= ERR_OK;
            pll_cnt    <= '0;
        end else begin
            if (st == S_PLL) pll_cnt <= pll_cnt + 1'b1;
            else             pll_cnt <= '0;
            unique case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        tgt_q      <= req_rate;
                        err_q      <= ERR_OK;
                        kind_pll_q <= 1'b0;
                        if (req_rate[CODE_W-1]) begin
                            step_q <= THRESH_CODE;
                            via_q  <= cur_q[CODE_W-1];
                        end else begin
                            step_q <= req_rate[LOW_W-1:0];
                            via_q  <= 1'b0;
                        end
                    end
                end
                S_LOOKUP: if (!ent.ok) err_q <= ERR_UNSUP;
                S_POLL:   if (!poll_clear && poll_expired) err_q <= ERR_BUSY;
                S_WRITE: begin
                    if (!kind_pll_q && via_q) begin
                        via_q <= 1'b0;
                    end else begin
                        cur_q <= tgt_q;
                    end
                end
                S_PLL: begin
                    if (pll_ack)       kind_pll_q <= 1'b1;
                    else if (pll_late) err_q <= ERR_NOACK;
                end
                default: ;
            endcase
        end
    end

    // control word to write
    always_comb begin
        wr_w      = rd_w;
        wr_w.busy = 1'b0;
        if (kind_pll_q) begin
            wr_w.src = SRC_PLL;
        end else begin
            wr_w.src = SRC_FIXED;
            wr_w.sel = ~rd_w.sel;
            if (rd_w.sel) begin
                wr_w.div0  = ent.div;
                wr_w.pre0  = ent.pre;
                wr_w.post0 = ent.post;
            end else begin
                wr_w.div1  = ent.div;
                wr_w.pre1  = ent.pre;
                wr_w.post1 = ent.post;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (st == S_IDLE);
        ctl_we    = (st == S_WRITE);
        ctl_wdata = wr_w;
        pll_req   = (st == S_PLL);
        pll_rate  = tgt_q[LOW_W-1:0];
        done      = (st == S_DONE);
        err       = err_q;
        cur_rate  = cur_q;
    end

endmodule

// File: rtl/clk_rate_sequencer_chk.sv
module clk_rate_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] ctl_rdata,
    input logic        ctl_we,
    input logic        pll_req,
    input logic [2:0]  pll_rate,
    input logic        pll_ack,
    input logic        done,
    input logic [1:0]  err,
    input logic [3:0]  cur_rate
);

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_no_ready_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r9_not_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    a_r6_write_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |-> !$past(ctl_rdata[31]));

    a_r4_pll_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_req && !pll_ack) |=> $stable(pll_rate));

    a_r2_write_not_during_pll: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_we && pll_req));

    a_r8_rate_moves_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(cur_rate));

    a_r8_rate_kept_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err != 2'b00) |-> $stable(cur_rate));

endmodule

bind clk_rate_sequencer clk_rate_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ctl_rdata (ctl_rdata),
    .ctl_we    (ctl_we),
    .pll_req   (pll_req),
    .pll_rate  (pll_rate),
    .pll_ack   (pll_ack),
    .done      (done),
    .err       (err),
    .cur_rate  (cur_rate)
);

// File: tb/clk_rate_sequencer_bench.sv
module clk_rate_sequencer_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_rate = '0;
    logic        req_ready;
    logic [31:0] ctl_rdata;
    logic        ctl_we;
    logic [31:0] ctl_wdata;
    logic        pll_req;
    logic [2:0]  pll_rate;
    logic        pll_ack = 1'b0;
    logic        done;
    logic [1:0]  err;
    logic [3:0]  cur_rate;

    clk_rate_sequencer u_clk_rate_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rate(req_rate),
        .req_ready(req_ready), .ctl_rdata(ctl_rdata), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .pll_req(pll_req), .pll_rate(pll_rate),
        .pll_ack(pll_ack), .done(done), .err(err), .cur_rate(cur_rate)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // environment: external control word, busy flag, PLL
    logic [30:0] ctl_reg = '0;
    logic        busy_hold = 1'b0;
    int          busy_left = 0;
    bit          ack_en = 1'b1;
    int          ack_cnt = 0;
    assign ctl_rdata = {busy_hold || (busy_left > 0), ctl_reg};

    always @(posedge clk) if (ctl_we) ctl_reg <= ctl_wdata[30:0];

    // reference model state
    logic [31:0] exp_writes[$];
    int          exp_plls[$];
    logic [30:0] model_reg = '0;
    logic [3:0]  exp_cur = 4'd7;
    logic [1:0]  exp_err = 2'b00;
    bit          model_busy = 1'b0;
    bit          run_chk = 1'b0;
    bit          prev_pll = 1'b0;
    int          cyc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic bit rom_ok(input int c);
        return (c <= 4) || (c == 7);
    endfunction

    task automatic push_fixed(input int c);
        logic [31:0] w;
        w = {1'b0, model_reg};
        w[0] = 1'b0;
        w[1] = ~model_reg[1];
        if (w[1]) begin
            w[16:11] = 6'(2 * c + 1); w[18:17] = 2'(c % 4); w[19] = 1'((c >> 2) & 1);
        end else begin
            w[7:2] = 6'(2 * c + 1); w[9:8] = 2'(c % 4); w[10] = 1'((c >> 2) & 1);
        end
        model_reg = w[30:0];
        exp_writes.push_back(w);
    endtask

    task automatic push_src();
        logic [31:0] w;
        w = {1'b0, model_reg};
        w[0] = 1'b1;
        model_reg = w[30:0];
        exp_writes.push_back(w);
    endtask

    task automatic plan(input logic [3:0] code);
        exp_err = 2'b00;
        if (!code[3]) begin
            if (!rom_ok(int'(code[2:0])))  exp_err = 2'b01;
            else if (busy_hold)            exp_err = 2'b10;
            else                           push_fixed(int'(code[2:0]));
        end else begin
            if (exp_cur[3]) begin
                if (busy_hold) begin exp_err = 2'b10; return; end
                push_fixed(7);
            end
            exp_plls.push_back(int'(code[2:0]));
            if (!ack_en)        exp_err = 2'b11;
            else if (busy_hold) exp_err = 2'b10;
            else                push_src();
        end
        if (exp_err == 2'b00) exp_cur = code;
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (busy_left > 0) busy_left--;
        if (pll_req && ack_en) begin ack_cnt++; pll_ack <= (ack_cnt == 3); end
        else begin ack_cnt = 0; pll_ack <= 1'b0; end
        if (run_chk) begin
            check(req_ready == !model_busy, "R9", "req_ready", req_ready, !model_busy);
            if (ctl_we) begin
                if (exp_writes.size() == 0)
                    check(0, "R2", "unexpected write", ctl_wdata, 0);
                else begin
                    logic [31:0] e;
                    e = exp_writes.pop_front();
                    check(ctl_wdata == e, "R2", "write word", ctl_wdata, e);
                end
            end
            if (pll_req && !prev_pll) begin
                if (exp_plls.size() == 0)
                    check(0, "R4", "unexpected pll_req", pll_rate, 0);
                else begin
                    int p;
                    p = exp_plls.pop_front();
                    check(int'(pll_rate) == p, "R4", "pll_rate", pll_rate, p);
                end
            end
            if (done) begin
                check(err == exp_err, "R6", "result code", err, exp_err);
                check(cur_rate == exp_cur, "R8", "cur_rate", cur_rate, exp_cur);
                check(exp_writes.size() == 0 && exp_plls.size() == 0, "R5",
                      "missing events", exp_writes.size() + exp_plls.size(), 0);
                model_busy = 1'b0;
            end
        end
        prev_pll = pll_req;
        if (cyc > 150000) begin
            check(0, "R9", "watchdog expired", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run(input logic [3:0] code, input int extra_valid);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        plan(code);
        req_valid = 1'b1;
        req_rate  = code;
        @(posedge clk);
        #1;
        model_busy = 1'b1;
        if (extra_valid > 0) begin
            req_rate = 4'd1;
            repeat (extra_valid) @(posedge clk);
            #1;
        end
        req_valid = 1'b0;
        wait (model_busy == 1'b0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        check(done == 1'b0 && ctl_we == 1'b0 && pll_req == 1'b0, "R1", "strobes",
              {done, ctl_we, pll_req}, 0);
        check(cur_rate == 4'd7, "R1", "cur_rate", cur_rate, 7);
        run_chk = 1'b1;

        run(4'd3, 0);   // R2: path 1 loaded, select flips to 1
        run(4'd1, 0);   // R2: ping-pong back to path 0, path 1 kept
        run(4'd5, 0);   // R3: absent entry
        run(4'd9, 3);   // R4: low to high; R9: extra valid ignored
        run(4'd12, 0);  // R5: high to high via code 7
        run(4'd6, 0);   // R3/R8: absent entry, rate stays high
        run(4'd4, 0);   // R2: high to low, direct

        busy_left = 1500;
        run(4'd2, 0);   // R6: flag clears before a later poll
        busy_hold = 1'b1;
        run(4'd0, 0);   // R6: flag never clears, timeout
        busy_hold = 1'b0;

        ack_en = 1'b0;
        run(4'd10, 0);  // R7: no acknowledge from low rate
        ack_en = 1'b1;
        run(4'd11, 0);  // R4: reach a high rate
        ack_en = 1'b0;
        run(4'd13, 0);  // R5/R7/R8: intermediate write, then no ack
        ack_en = 1'b1;
        run(4'd13, 0);  // R5: retry succeeds
        run(4'd7, 0);   // R2: exactly threshold uses divided path

        check(ctl_reg == model_reg, "R2", "final control word", ctl_reg, model_reg);
        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule